// File: doc/BRIEF.md
# Change-Compressed Logic Capture Engine

This block records activity on a bank of asynchronous probe inputs, all sampled by one free-running sample clock. Every probe first passes through a two-register synchronizer. The host then arms the engine with a level trigger on a single selected channel. Once that level appears, the engine stores a record only in the cycles where the synchronized probe vector changes. Each record holds the new vector together with a timestamp, measured in sample clocks, that starts at zero when the trigger fires. Recording only changes lets a modest on-chip memory cover long stretches of slow or bursty traffic.

A narrow host command port accepts three operations: clear, set-trigger and dump. A dump streams the stored data as bytes through a valid/ready handshake to a serial transmitter. The stream starts with the record count and then sends every record in capture order. The host can rebuild the waveform from the record values and timestamps alone.

Top module: `xcap_engine`

## Requirements
- R1: Each probe input passes through two clocked register stages before any capture logic uses it. If the trigger level reaches the pins before clock edge k and a change reaches them before edge k+d, the change is stored with timestamp d.
- R2: A command with op code 2'b10 loads the channel index and polarity, clears the stored records and the full flag, and raises `armed`. Capture begins, and `capturing` rises, only when the selected synchronized channel equals the polarity bit. Levels on other channels, and the opposite level on the selected channel, keep the engine armed.
- R3: The first record after the trigger holds the probe vector seen at the trigger, with timestamp 0.
- R4: While capturing, a record is written only in a cycle where the synchronized vector differs from the vector of the previous cycle (R5 adds the only exception).
- R5: The timestamp is a TS_W-bit counter that advances every sample clock from the trigger. When it holds all ones, a record is written even if the vector has not changed, and the counter then wraps to zero.
- R6: When DEPTH records are stored, capture stops: `full` goes high and `capturing` goes low. Later probe changes add no records.
- R7: A command with op code 2'b01 lowers `armed`, `capturing` and `full` and sets the record count to zero.
- R8: A command with op code 2'b11 starts a dump. The dump sends the record count, least significant byte first, in ceil((log2(DEPTH)+1)/8) bytes. It then sends each record in capture order, least significant byte first, in ceil((NCH+TS_W)/8) bytes. A record holds the probe vector in bits [NCH-1:0] and the timestamp in bits [NCH+TS_W-1:NCH], with zeros above.
- R9: A byte is transferred only on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R10: `busy` rises on the edge that accepts a dump and stays high through the final byte handshake. It falls on that same edge.
- R11: A dump command is ignored while `armed` or `capturing` is high: `busy` and `tx_valid` stay low.
- R12: While `busy` is high, every command is ignored, so stored records and the full flag are unchanged.
- R13: The synchronous `rst` input, while high, forces `armed`, `capturing`, `full`, `busy` and `tx_valid` low and clears the trigger setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_in | input | NCH | Asynchronous probe inputs |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 01 clear, 10 set trigger, 11 dump, 00 none |
| cmd_chan | input | log2(NCH) | Trigger channel index for set trigger |
| cmd_pol | input | 1 | Trigger level for set trigger |
| tx_data | output | 8 | Dump byte toward the serial transmitter |
| tx_valid | output | 1 | Dump byte is valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| armed | output | 1 | Waiting for the trigger level |
| capturing | output | 1 | Trigger seen, recording changes |
| full | output | 1 | Memory filled, capture stopped |
| busy | output | 1 | Dump in progress |

## Verification
A lost or duplicated write-pointer update shows up at the first dump as a wrong count byte, and every later record in that dump is shifted. A timestamp counter that starts one cycle off corrupts every stored time by the same constant, and the wrap rule turns any fault in the counter into forced records at the wrong spacing. Faults in the dump sequencer appear within one byte of the handshake: a byte is lost or repeated, or the data moves while the transmitter is stalled. A change detector that compares against the wrong vector shows up as missing or extra records in the first capture.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_TRIG  = 2'b10,
    OP_DUMP  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_ARMED,
    CS_RUN,
    CS_FULL
  } cap_state_e;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_SEND,
    DS_READ,
    DS_LOAD
  } dump_state_e;

endpackage

// File: rtl/xcap_sync.sv
module xcap_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= g_stage[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/xcap_recorder.sv
module xcap_recorder
  import xcap_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int TS_W  = 16,
  parameter int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = $clog2(NCH),
  localparam int REC_W = NCH + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   smp,
  input  logic             cmd_clear,
  input  logic             cmd_trig,
  input  logic [CHW-1:0]   cmd_chan,
  input  logic             cmd_pol,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [REC_W-1:0] wr_data,
  output logic [AW:0]      rec_count,
  output logic             armed,
  output logic             capturing,
  output logic             full
);

  cap_state_e       st;
  logic [CHW-1:0]   sel;
  logic             pol;
  logic [NCH-1:0]   prev;
  logic [TS_W-1:0]  ts;
  logic [AW:0]      wptr;
  logic             hit, chg, wrap, last;

  assign hit  = (smp[sel] == pol);
  assign chg  = (smp != prev);
  assign wrap = &ts;
  assign last = (wptr == (AW+1)'(DEPTH - 1));

  always_comb begin
    wr_en = 1'b0;
    case (st)
      CS_ARMED: wr_en = hit;
      CS_RUN:   wr_en = chg | wrap;
      default:  wr_en = 1'b0;
    endcase
  end

  assign wr_addr   = wptr[AW-1:0];
  assign wr_data   = {ts, smp};
  assign rec_count = wptr;
  assign armed     = (st == CS_ARMED);
  assign capturing = (st == CS_RUN);
  assign full      = (st == CS_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= CS_IDLE;
      sel  <= '0;
      pol  <= 1'b0;
      prev <= '0;
      ts   <= '0;
      wptr <= '0;
    end else if (cmd_clear) begin
      st   <= CS_IDLE;
      ts   <= '0;
      wptr <= '0;
    end else if (cmd_trig) begin
      st   <= CS_ARMED;
      sel  <= cmd_chan;
      pol  <= cmd_pol;
      ts   <= '0;
      wptr <= '0;
    end else begin
      if (wr_en) begin
        prev <= smp;
        wptr <= wptr + 1'b1;
        st   <= last ? CS_FULL : CS_RUN;
      end
      if (st == CS_RUN || (st == CS_ARMED && hit)) ts <= ts + 1'b1;
    end
  end

  // R6: no writes once memory is full, pointer never passes depth
  assert_full_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);
  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (rst)
    wptr <= (AW+1)'(DEPTH));
  // R3: the record at address zero carries timestamp zero
  assert_first_ts_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wptr == '0) |-> (wr_data[REC_W-1:NCH] == '0));
  // R2: capture only begins from the armed state
  assert_start_from_armed_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(capturing) |-> $past(armed));

endmodule

// File: rtl/xcap_ram.sv
module xcap_ram #(
  parameter int W     = 24,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xcap_dump.sv
module xcap_dump
  import xcap_pkg::*;
#(
  parameter int REC_W = 24,
  parameter int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1,
  localparam int CB    = (CNT_W + 7) / 8,
  localparam int RB    = (REC_W + 7) / 8,
  localparam int SB    = (CB > RB) ? CB : RB,
  localparam int SH_W  = SB * 8,
  localparam int BIW   = $clog2(SB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW:0]      count,
  output logic [AW-1:0]    rd_addr,
  input  logic [REC_W-1:0] rd_data,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             busy
);

  dump_state_e      st;
  logic [SH_W-1:0]  sh;
  logic [BIW-1:0]   left;
  logic [AW:0]      total;
  logic [AW:0]      idx;
  logic             fire;

  assign fire    = tx_valid & tx_ready;
  assign tx_data = sh[7:0];
  assign rd_addr = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= DS_IDLE;
      sh       <= '0;
      left     <= '0;
      total    <= '0;
      idx      <= '0;
      tx_valid <= 1'b0;
      busy     <= 1'b0;
    end else begin
      case (st)
        DS_IDLE: begin
          if (start) begin
            sh       <= SH_W'(count);
            left     <= BIW'(CB);
            total    <= count;
            idx      <= '0;
            tx_valid <= 1'b1;
            busy     <= 1'b1;
            st       <= DS_SEND;
          end
        end
        DS_SEND: begin
          if (fire) begin
            sh   <= sh >> 8;
            left <= left - 1'b1;
            if (left == BIW'(1)) begin
              tx_valid <= 1'b0;
              if (idx == total) begin
                busy <= 1'b0;
                st   <= DS_IDLE;
              end else begin
                st <= DS_READ;
              end
            end
          end
        end
        DS_READ: st <= DS_LOAD;
        DS_LOAD: begin
          sh       <= SH_W'(rd_data);
          left     <= BIW'(RB);
          idx      <= idx + 1'b1;
          tx_valid <= 1'b1;
          st       <= DS_SEND;
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

  // R9: a stalled byte holds its value
  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10: bytes only appear inside a busy window
  assert_valid_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);
  assert_idx_bound_R8: assert property (@(posedge clk) disable iff (rst)
    idx <= total);

endmodule

// File: rtl/xcap_engine.sv
module xcap_engine
  import xcap_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int TS_W        = 16,
  parameter int DEPTH       = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = $clog2(NCH),
  localparam int REC_W = NCH + TS_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] probe_in,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [CHW-1:0] cmd_chan,
  input  logic           cmd_pol,
  output logic [7:0]     tx_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic           armed,
  output logic           capturing,
  output logic           full,
  output logic           busy
);

  logic [NCH-1:0]   smp;
  logic             cmd_clear, cmd_trig, dump_go;
  logic             wr_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [REC_W-1:0] wr_data, rd_data;
  logic [AW:0]      rec_count;
  op_e              op;

  assign op        = op_e'(cmd_op);
  assign cmd_clear = cmd_valid && !busy && (op == OP_CLEAR);
  assign cmd_trig  = cmd_valid && !busy && (op == OP_TRIG);
  assign dump_go   = cmd_valid && !busy && (op == OP_DUMP) && !armed && !capturing;

  xcap_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (probe_in),
    .q   (smp)
  );

  xcap_recorder #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH)) u_rec (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp),
    .cmd_clear (cmd_clear),
    .cmd_trig  (cmd_trig),
    .cmd_chan  (cmd_chan),
    .cmd_pol   (cmd_pol),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rec_count (rec_count),
    .armed     (armed),
    .capturing (capturing),
    .full      (full)
  );

  xcap_ram #(.W(REC_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  xcap_dump #(.REC_W(REC_W), .DEPTH(DEPTH)) u_dump (
    .clk      (clk),
    .rst      (rst),
    .start    (dump_go),
    .count    (rec_count),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .busy     (busy)
  );

  // R11: a dump never starts out of an armed or capturing state
  assert_dump_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(armed) && !$past(capturing)));
  // R12: stored data is frozen while a dump runs
  assert_cmd_locked_R12: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(rec_count) && $stable(full)));
  // R13: leaving reset finds every status output low
  assert_reset_state_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !tx_valid && !armed && !capturing && !full));

endmodule

// File: tb/xcap_engine_test.sv
module xcap_engine_test;

  localparam int NCH   = 4;
  localparam int TS_W  = 8;
  localparam int DEPTH = 8;
  localparam int RB    = 2;
  localparam int NTAB  = 11;

  // each entry: {gap in clocks since previous drive, probe vector}
  localparam logic [11:0] TBL [NTAB] = '{
    {8'd0, 4'b0001}, {8'd3, 4'b0011}, {8'd5, 4'b0011}, {8'd2, 4'b0010},
    {8'd1, 4'b1010}, {8'd1, 4'b1011}, {8'd4, 4'b1011}, {8'd7, 4'b0100},
    {8'd6, 4'b0101}, {8'd2, 4'b0111}, {8'd3, 4'b1111}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] probe = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_chan = 2'b00;
  logic cmd_pol = 1'b0;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid, armed, capturing, full, busy;

  int checks = 0;
  int errors = 0;
  logic [7:0]  got [$];
  logic [11:0] exp_rec [$];

  always #5 clk = ~clk;

  xcap_engine #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .probe_in(probe), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_pol(cmd_pol),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .armed(armed), .capturing(capturing), .full(full), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [1:0] ch, input logic pl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_pol = pl;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic collect(input int nbytes, input bit inject);
    bit stalled = 1'b0;
    bit busy_bad = 1'b0;
    logic [7:0] held = '0;
    got.delete();
    for (int c = 0; c < 400 && got.size() < nbytes; c++) begin
      if (stalled)
        check(tx_valid && tx_data == held, "R9 stalled byte held", int'(tx_data), int'(held));
      if (!busy) busy_bad = 1'b1;
      if (inject && c == 4) begin cmd_valid = 1'b1; cmd_op = 2'b01; end
      if (inject && c == 5) begin cmd_valid = 1'b0; cmd_op = 2'b00; end
      tx_ready = ((c % 3) != 1);
      stalled = tx_valid && !tx_ready;
      held = tx_data;
      if (tx_valid && tx_ready) got.push_back(tx_data);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    tx_ready = 1'b0;
    check(!busy_bad, "R10 busy high during dump", int'(busy_bad), 0);
    check(busy == 1'b0, "R10 busy falls after last byte", int'(busy), 0);
    check(got.size() == nbytes, "R8 byte count", got.size(), nbytes);
  endtask

  task automatic check_records(input string tag);
    for (int k = 0; k < exp_rec.size(); k++) begin
      logic [15:0] act;
      if (2*k + 2 < got.size()) act = {got[2*k+2], got[2*k+1]};
      else act = 16'hffff;
      check(act == {4'b0, exp_rec[k]}, tag, int'(act), int'({4'b0, exp_rec[k]}));
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cum = 0;
    logic [3:0] pv = '0;
    logic [3:0] wv;
    int waited;

    // R13: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!armed && !capturing && !full && !busy && !tx_valid, "R13 reset outputs",
          int'({armed, capturing, full, busy, tx_valid}), 0);

    // R2: arm on channel 0 high; other channels wiggle without triggering
    probe = 4'b0110;
    send_cmd(2'b10, 2'd0, 1'b1);
    repeat (5) @(negedge clk);
    check(armed && !capturing, "R2 armed, no trigger yet", int'({armed, capturing}), 2);

    // R11: dump while armed is ignored
    send_cmd(2'b11, 2'd0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check(!busy && !tx_valid, "R11 dump ignored while armed", int'({busy, tx_valid}), 0);
      @(negedge clk);
    end

    // expected records from the table
    exp_rec.delete();
    for (int i = 0; i < NTAB; i++) begin
      cum += int'(TBL[i][11:4]);
      if ((i == 0 || TBL[i][3:0] != pv) && exp_rec.size() < DEPTH)
        exp_rec.push_back({cum[7:0], TBL[i][3:0]});
      pv = TBL[i][3:0];
    end

    // walk the stimulus table
    for (int i = 0; i < NTAB; i++) begin
      repeat (int'(TBL[i][11:4])) @(negedge clk);
      if (i == 1) check(capturing && !armed, "R2 capture after trigger level",
                        int'({capturing, armed}), 2);
      probe = TBL[i][3:0];
    end
    repeat (6) @(negedge clk);
    check(full && !capturing && !armed, "R6 full stops capture",
          int'({full, capturing, armed}), 4);

    // R8 / R12: dump with a clear command injected mid-stream
    send_cmd(2'b11, 2'd0, 1'b0);
    collect(1 + DEPTH*RB, 1'b1);
    check(got.size() > 0 && got[0] == 8'(DEPTH), "R8 R6 count byte",
          got.size() > 0 ? int'(got[0]) : -1, DEPTH);
    check_records("R1 R3 R4 R8 record");
    check(full == 1'b1, "R12 clear ignored during dump", int'(full), 1);

    // R7: clear, then dump sends a zero count only
    send_cmd(2'b01, 2'd0, 1'b0);
    check(!full && !armed && !capturing, "R7 clear status", int'({full, armed, capturing}), 0);
    send_cmd(2'b11, 2'd0, 1'b0);
    collect(1, 1'b0);
    check(got.size() == 1 && got[0] == 8'd0, "R7 count zero",
          got.size() > 0 ? int'(got[0]) : -1, 0);

    // R5 / R2 low polarity: trigger on channel 2 low, then hold the vector
    probe = 4'b0100;
    send_cmd(2'b10, 2'd2, 1'b0);
    repeat (4) @(negedge clk);
    check(armed && !capturing, "R2 opposite level keeps armed", int'({armed, capturing}), 2);
    wv = 4'b1000;
    probe = wv;
    waited = 0;
    while (!full && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(full == 1'b1, "R5 forced records fill memory", int'(full), 1);
    exp_rec.delete();
    exp_rec.push_back({8'd0, wv});
    for (int k = 1; k < DEPTH; k++) exp_rec.push_back({8'hff, wv});
    send_cmd(2'b11, 2'd0, 1'b0);
    collect(1 + DEPTH*RB, 1'b0);
    check(got.size() > 0 && got[0] == 8'(DEPTH), "R5 count byte",
          got.size() > 0 ? int'(got[0]) : -1, DEPTH);
    check_records("R5 wrap record");

    // R13: reset from a full state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!armed && !capturing && !full && !busy && !tx_valid, "R13 reset from full",
          int'({armed, capturing, full, busy, tx_valid}), 0);
    rst = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule